// File: doc/BRIEF.md
# Multiplierless Transposed FIR Filter

This block is an eight-tap FIR filter with fixed coefficients. It takes one signed sample per clock and returns one filtered result per clock. It does not interpolate or decimate. The taps are arranged in transposed form. Every product of the newest sample is therefore needed in the same cycle, and all of them come from one shared network of shifts, adds and subtracts. The datapath contains no multiply operator.

Each coefficient magnitude is written as a short signed-digit sum: 3 = 2+1, 5 = 4+1, 9 = 8+1, 11 = 8+3 and 23 = 32-9. The terms 3x and 9x are formed once and reused to build 11x and 23x. The sign of a coefficient is not computed in the network. It is applied by the tap adder, which either adds or subtracts the term. The network is two adder levels deep, and an elaboration check holds it within a configurable limit.

Both streams use valid/ready. A sample transfers on a clock edge where `i_valid` and `i_ready` are both high. A result transfers on an edge where `o_valid` and `o_ready` are both high. The whole pipeline advances when `o_valid` is low or `o_ready` is high. `i_ready` follows that condition in the same cycle, so it can fall combinationally when the consumer stalls. A producer may hold `i_valid` low for any number of cycles.

Top module: `shiftadd_fir`

## Requirements
- R1: During and after reset, `o_valid` is low, `i_ready` is high and all tap history is zero. The first results after reset therefore treat earlier samples as zero.
- R2: Each tap product equals the sample times the tap coefficient for every input value, including the most negative one, and no multiplier is used.
- R3: For accepted samples x[n], the results are y[n] = sum over k=0..7 of C[k]·x[n-k]. The coefficients are C = 23, -11, 5, 3, -5, 11, 9, -3, with tap 0 applied to the newest sample.
- R4: `o_data` is DW+7 bits wide, two's complement. It holds the exact sum for any full-scale signed input sequence, with no wrap.
- R5: With `o_ready` held high, a sample accepted on clock edge E has its result on `o_data`, with `o_valid` high, just after edge E+2 (three register stages).
- R6: While `o_valid` is high and `o_ready` is low, the next cycle keeps `o_valid` high and `o_data` unchanged, and `i_ready` is low.
- R7: Cycles with `i_valid` low do not shift the tap history. The output sequence depends only on the accepted samples and their order.
- R8: Each accepted sample yields exactly one result, in order. With `o_ready` held high, a sample can be accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| i_valid | input | 1 | Input sample present |
| i_ready | output | 1 | Block can take a sample this cycle |
| i_data | input | DW | Signed input sample |
| o_valid | output | 1 | Result present |
| o_ready | input | 1 | Consumer takes the result this cycle |
| o_data | output | DW+7 | Signed full-precision filtered result |

## Verification
The overflow assertion relies on every sample being a DW-bit two's-complement value. The bench drives each sample as a DW-bit slice and includes runs where the most negative and most positive values are aligned with the coefficient signs. The hold and blocking assertions expect `o_ready` to change only between clock edges. The bench changes `o_ready` and the input handshake only at the falling edge, including random stall patterns. The term check assumes the sample register holds a defined value once reset is released, which the reset clause guarantees.

// File: rtl/fir_csd_pkg.sv
package fir_csd_pkg;

  localparam int NTAPS  = 8;
  localparam int NSLOTS = 5;

  // Tap 0 multiplies the newest sample.
  localparam int TAP_COEF [NTAPS]  = '{23, -11, 5, 3, -5, 11, 9, -3};
  // Magnitudes the shared network produces, in slot order.
  localparam int SLOT_MAG [NSLOTS] = '{3, 5, 9, 11, 23};
  // Adder levels of the shared network (3,5,9 on level one; 11,23 on level two).
  localparam int NET_LEVELS = 2;

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int slot_of(int mag);
    int idx;
    idx = -1;
    for (int i = 0; i < NSLOTS; i++)
      if (SLOT_MAG[i] == mag) idx = i;
    return idx;
  endfunction

  function automatic int coef_abs_sum();
    int s;
    s = 0;
    for (int i = 0; i < NTAPS; i++) s += iabs(TAP_COEF[i]);
    return s;
  endfunction

  function automatic int max_slot_mag();
    int m;
    m = 0;
    for (int i = 0; i < NSLOTS; i++)
      if (SLOT_MAG[i] > m) m = SLOT_MAG[i];
    return m;
  endfunction

endpackage

// File: rtl/fir_flow_ctrl.sv
module fir_flow_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic i_valid,
  input  logic o_ready,
  output logic adv,
  output logic v_x,
  output logic v_t,
  output logic o_valid
);

  // One enable for every stage: move when the output slot is free or drained.
  assign adv = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_x     <= 1'b0;
      v_t     <= 1'b0;
      o_valid <= 1'b0;
    end else if (adv) begin
      v_x     <= i_valid;
      v_t     <= v_x;
      o_valid <= v_t;
    end
  end

endmodule

// File: rtl/csd_term_net.sv
module csd_term_net
  import fir_csd_pkg::*;
#(
  parameter int DW = 12,
  parameter int PW = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  output logic signed [PW-1:0] term_q [NSLOTS]
);

  logic signed [PW-1:0] xe, t3, t5, t9, t11, t23;
  logic signed [PW-1:0] term_d [NSLOTS];

  assign xe = PW'(x);

  // Level one: single shift-add terms.
  assign t3  = xe + (xe <<< 1);
  assign t5  = xe + (xe <<< 2);
  assign t9  = xe + (xe <<< 3);
  // Level two: reuse of 3x and 9x.
  assign t11 = (xe <<< 3) + t3;
  assign t23 = (xe <<< 5) - t9;

  always_comb begin
    term_d[0] = t3;
    term_d[1] = t5;
    term_d[2] = t9;
    term_d[3] = t11;
    term_d[4] = t23;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) term_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < NSLOTS; i++) term_q[i] <= term_d[i];
    end
  end

  // R2: every shared term matches the slot magnitude table.
  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NSLOTS; i++) begin
        a_r2_terms_exact: assert (int'(term_d[i]) == int'(x) * SLOT_MAG[i])
          else $error("term slot %0d wrong", i);
      end
    end
  end

endmodule

// File: rtl/fir_tap_chain.sv
module fir_tap_chain
  import fir_csd_pkg::*;
#(
  parameter int PW = 17,
  parameter int AW = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [PW-1:0] term [NSLOTS],
  output logic signed [AW-1:0] y
);

  logic signed [AW-1:0] acc_q [NTAPS];
  logic signed [AW:0]   nxt   [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam int MAG = iabs(TAP_COEF[k]);
    localparam int SL  = slot_of(MAG);
    localparam bit NEG = TAP_COEF[k] < 0;

    logic signed [AW:0] up, prod;

    if (k == NTAPS - 1) begin : g_last
      assign up = '0;
    end else begin : g_mid
      assign up = (AW+1)'(acc_q[k+1]);
    end

    assign prod = (AW+1)'(term[SL]);

    // The coefficient sign is folded into the chain adder.
    if (NEG) begin : g_sub
      assign nxt[k] = up - prod;
    end else begin : g_add
      assign nxt[k] = up + prod;
    end

    // R4: the guard bit always agrees with the sign bit.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (nxt[k][AW] == nxt[k][AW-1]))
      else $error("tap %0d sum overflows", k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) acc_q[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < NTAPS; k++) acc_q[k] <= nxt[k][AW-1:0];
    end
  end

  assign y = acc_q[0];

endmodule

// File: rtl/shiftadd_fir.sv
module shiftadd_fir
  import fir_csd_pkg::*;
#(
  parameter  int DW            = 12,
  parameter  int NET_DEPTH_MAX = 4,
  localparam int AW            = DW + $clog2(coef_abs_sum() + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 i_valid,
  output logic                 i_ready,
  input  logic signed [DW-1:0] i_data,
  output logic                 o_valid,
  input  logic                 o_ready,
  output logic signed [AW-1:0] o_data
);

  localparam int PW = DW + $clog2(max_slot_mag() + 1);

  if (NET_LEVELS > NET_DEPTH_MAX) begin : g_depth_chk
    $error("shared term network is deeper than NET_DEPTH_MAX");
  end

  logic                 adv, v_x, v_t;
  logic signed [DW-1:0] x_q;
  logic signed [PW-1:0] terms [NSLOTS];

  fir_flow_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (i_valid),
    .o_ready (o_ready),
    .adv     (adv),
    .v_x     (v_x),
    .v_t     (v_t),
    .o_valid (o_valid)
  );

  assign i_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n)                x_q <= '0;
    else if (adv && i_valid)   x_q <= i_data;
  end

  csd_term_net #(.DW(DW), .PW(PW)) u_net (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .x      (x_q),
    .term_q (terms)
  );

  fir_tap_chain #(.PW(PW), .AW(AW)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv && v_t),
    .term  (terms),
    .y     (o_data)
  );

  // R6: a stalled result stays put.
  a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)))
    else $error("stalled result changed");

  // R6: no sample is taken while the result is stalled.
  a_r6_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> !i_ready)
    else $error("input accepted during stall");

endmodule

// File: tb/sim_shiftadd_fir.sv
module sim_shiftadd_fir;

  localparam int DW = 12;
  localparam int AW = DW + 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n, i_valid, i_ready, o_valid, o_ready;
  logic signed [DW-1:0] i_data;
  logic signed [AW-1:0] o_data;

  shiftadd_fir #(.DW(DW)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (i_valid),
    .i_ready (i_ready),
    .i_data  (i_data),
    .o_valid (o_valid),
    .o_ready (o_ready),
    .o_data  (o_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int coef [8] = '{23, -11, 5, 3, -5, 11, 9, -3};
  int hist [8] = '{default: 0};
  int exp_q [$];
  int itq [$];
  int iter = 0;
  bit chk_lat = 1'b0;
  bit prev_stall = 1'b0;
  logic signed [AW-1:0] prev_data = '0;
  string tag = "R3";

  task automatic check(string rq, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
    end
  endtask

  task automatic step(bit v, int d, bit rdy);
    int e, a, xs, s;
    @(negedge clk);
    i_valid = v;
    i_data  = d[DW-1:0];
    o_ready = rdy;
    #1;
    if (prev_stall) begin
      check("R6 held valid", int'(o_valid), 1);
      check("R6 held data", int'(o_data), int'(prev_data));
    end
    if (o_valid && !o_ready) check("R6 input blocked", int'(i_ready), 0);
    prev_stall = o_valid && !o_ready;
    prev_data  = o_data;
    if (o_valid && o_ready) begin
      if (exp_q.size() == 0) check("R8 unexpected result", 1, 0);
      else begin
        e = exp_q.pop_front();
        a = itq.pop_front();
        check(tag, int'(o_data), e);
        if (chk_lat) check("R5 latency", iter - a, 3);
      end
    end
    if (i_valid && i_ready) begin
      xs = int'(i_data);
      for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = xs;
      s = 0;
      for (int k = 0; k < 8; k++) s += coef[k] * hist[k];
      exp_q.push_back(s);
      itq.push_back(iter);
    end
    iter++;
  endtask

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; i_valid = 1'b0; o_ready = 1'b0; i_data = '0;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset o_valid", int'(o_valid), 0);
    check("R1 reset i_ready", int'(i_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Unit impulse: the result sequence is the coefficient list; zero history (R1).
    chk_lat = 1'b1;
    tag = "R3 R1 unit impulse";
    step(1, 1, 1);
    repeat (11) step(1, 0, 1);

    // Most negative impulse scales every tap product (R2).
    tag = "R2 scaled impulse";
    step(1, -2048, 1);
    repeat (10) step(1, 0, 1);

    // Back-to-back random samples (R8).
    tag = "R8 full rate";
    repeat (200) step(1, int'($urandom), 1);
    check("R8 in flight", exp_q.size(), 3);

    // Full-scale runs aligned with the coefficient signs (R4).
    tag = "R4 full scale";
    for (int r = 0; r < 4; r++) begin
      for (int k = 7; k >= 0; k--)
        step(1, ((coef[k] > 0) ^ r[0]) ? 2047 : -2048, 1);
    end
    repeat (10) step(1, -2048, 1);
    repeat (10) step(1, 2047, 1);

    // Idle input cycles must not shift history (R7).
    tag = "R7 bubbles";
    repeat (300) step(($urandom % 3) != 0, int'($urandom), 1);

    // Random consumer stalls (R6).
    chk_lat = 1'b0;
    tag = "R6 backpressure";
    repeat (400) step(($urandom % 4) != 0, int'($urandom), ($urandom % 3) != 0);

    // Drain: every accepted sample produced exactly one result (R8).
    tag = "R8 drain";
    repeat (8) step(0, 0, 1);
    check("R8 drained", exp_q.size(), 0);
    @(negedge clk);
    #1;
    check("R8 idle after drain", int'(o_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule